// File: doc/BRIEF.md
# Cascadable Reload Counter Bank

A bank of four 8-bit down-counters, each reloading from its own base register. A counter counts an external tick input, or it counts the borrows of the counter one index below it. Counters linked this way act as one wider counter of 16, 24 or 32 bits. The lowest counter of such a chain holds the least significant byte. Each time a chain runs out, the highest counter of the chain raises a one-cycle underflow pulse, and the whole chain reloads from the base bytes of its members.

Software reaches the bank through a byte-addressed request port that takes 1, 2 and 4 byte accesses. Address bits 3:2 pick the register group: 0 is mode, 1 is base, 2 is counter, and 3 is unmapped. Address bits 1:0 pick the counter index. The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. `req_ready` is tied high, so the port never applies back-pressure. Each accepted read returns `rsp_valid` and `rsp_rdata` in the following cycle, and there is no way to stall the response. Illegal requests raise `err` for one cycle. They change no register.

In a mode byte, bit 7 enables counting and bit 6 is the load flag. Bits 5:2 are reserved. Bits 1:0 select the clock: 00 counts the tick input, 11 cascades from the counter below, and 01 and 10 are not supported.

Top module: `ctrbank_top`

## Requirements
- R1: After reset, every mode, base and counter register reads as zero, and `uflow`, `err` and `rsp_valid` are low.
- R2: A counter whose clock select is 00 and whose reload value N is non-zero raises its `uflow` bit for one cycle after the Nth tick. It then reloads and underflows again every N ticks.
- R3: A mode write that selects code 11 on counter 0 is rejected: `err` pulses and the mode register keeps its old value.
- R4: A mode write is rejected if it has non-zero bits 5:2, has both bit 7 and bit 6 set, or uses clock code 01 or 10.
- R5: When counter k starts with code 00, each consecutive higher counter with code 11 extends the chain. Counter k+j supplies bits 8j+7:8j of the combined count and of the reload value. `uflow` pulses only on the highest counter of the chain.
- R6: Starting a chain head is rejected if any cascaded member of its chain does not have bit 7 set.
- R7: A base write to a running counter does not change its count. The new value is used at the next reload. When a base write and a reloading tick fall in the same cycle, the reload uses the base value held before that write.
- R8: Reading a stopped counter returns its base register. Reading a running counter returns its byte of the remaining tick count.
- R9: Writing bit 7 low to a chain head stops the chain at once, with no further `uflow`. Starting a counter whose combined reload value is zero leaves it stopped.
- R10: Writes to the counter group are rejected with `err`.
- R11: A 2-byte access is legal only at index 0 or 2, and a 4-byte access only at index 0. Size code 3 and group 3 are illegal. An illegal access pulses `err`, and an illegal read returns zero data.
- R12: In a multi-byte access, the lowest-numbered counter uses the most significant byte of the data word, for both reads and writes.
- R13: `req_ready` is always high, and every read request is followed by `rsp_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count tick, one cycle per count |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Always high, the request port never stalls |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Bits 3:2 group, bits 1:0 counter index |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data, right-aligned |
| uflow | output | 4 | One-cycle underflow pulse per counter |
| err | output | 1 | One-cycle pulse for a rejected access |

## Verification
Two events can land on the same clock edge: a base-register write and the tick that drives a running counter through its reload. The bench provokes this by driving the write request and the tick in the same cycle, while the counter holds one remaining tick. It then checks that the underflow pulse appears and that the counter reads back the old base value. It also checks that the base register reads back the new value, and that the next underflow comes exactly that many ticks later.

// File: rtl/ctrbank_pkg.sv
package ctrbank_pkg;
  typedef enum logic [1:0] {
    GRP_MODE  = 2'd0,
    GRP_BASE  = 2'd1,
    GRP_COUNT = 2'd2,
    GRP_NONE  = 2'd3
  } grp_e;

  localparam int BIT_RUN  = 7;
  localparam int BIT_LOAD = 6;
  localparam int RSV_HI   = 5;
  localparam int RSV_LO   = 2;

  localparam logic [1:0] CLK_TICK = 2'b00;
  localparam logic [1:0] CLK_CASC = 2'b11;
endpackage

// File: rtl/ctrbank_access.sv
module ctrbank_access
  import ctrbank_pkg::*;
#(
  parameter int NUM = 4,
  parameter int CW  = 8,
  parameter int DW  = 32,
  localparam int IW = $clog2(NUM),
  localparam int AW = IW + 2
) (
  input  logic [AW-1:0]             req_addr,
  input  logic [1:0]                req_size,
  input  logic [DW-1:0]             req_wdata,
  input  logic [NUM-1:0][CW-1:0]    mode_q,
  input  logic [NUM-1:0][CW-1:0]    base_q,
  input  logic [NUM-1:0][CW-1:0]    view,
  output grp_e                      grp,
  output logic                      acc_ok,
  output logic [NUM-1:0]            sel,
  output logic [NUM-1:0][CW-1:0]    wbyte,
  output logic [DW-1:0]             rdata
);
  localparam int DB = DW / CW;

  int idx, nb, k, sh;
  logic [NUM-1:0][CW-1:0] src;

  // decode, alignment and byte steering (lowest index -> most significant byte)
  always_comb begin
    grp    = grp_e'(req_addr[AW-1 -: 2]);
    idx    = int'(req_addr[IW-1:0]);
    nb     = 1 << int'(req_size);
    acc_ok = (grp != GRP_NONE) && (req_size != 2'd3) && (nb <= DB)
             && ((idx % nb) == 0) && (idx + nb <= NUM);
    case (grp)
      GRP_MODE: src = mode_q;
      GRP_BASE: src = base_q;
      default:  src = view;
    endcase
    sel   = '0;
    wbyte = '0;
    rdata = '0;
    k     = 0;
    sh    = 0;
    for (int i = 0; i < NUM; i++) begin
      if (acc_ok && i >= idx && i < idx + nb) begin
        k        = i - idx;
        sh       = (nb - 1 - k) * CW;
        sel[i]   = 1'b1;
        wbyte[i] = CW'(req_wdata >> sh);
        rdata    = rdata | (DW'(src[i]) << sh);
      end
    end
  end
endmodule

// File: rtl/ctrbank_core.sv
module ctrbank_core
  import ctrbank_pkg::*;
#(
  parameter int NUM = 4,
  parameter int CW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   mode_we,
  input  logic                   base_we,
  input  logic [NUM-1:0]         sel,
  input  logic [NUM-1:0][CW-1:0] wbyte,
  output logic [NUM-1:0][CW-1:0] mode_q,
  output logic [NUM-1:0][CW-1:0] base_q,
  output logic [NUM-1:0][CW-1:0] view,
  output logic [NUM-1:0]         uflow_q,
  output logic                   mode_bad
);
  localparam int TW = NUM * CW;

  logic [NUM-1:0][CW-1:0] mode_n, base_n, cnt_q, cnt_n, nm;
  logic [NUM-1:0]         run_q, run_n, uf_n, cas, ncas, chain_run;
  logic                   last_run, go;
  int                     top_c, top_s;
  logic [TW-1:0]          cur, rl;

  function automatic int chain_top(input logic [NUM-1:0] c, input int h);
    int  t;
    logic ok;
    t  = h;
    ok = 1'b1;
    for (int j = 0; j < NUM; j++) begin
      if (j > h) begin
        if (ok && c[j]) t = j;
        else            ok = 1'b0;
      end
    end
    return t;
  endfunction

  function automatic logic [TW-1:0] pack_bytes(input logic [NUM-1:0][CW-1:0] v,
                                               input int h, input int t);
    logic [TW-1:0] r;
    r = '0;
    for (int k = 0; k < NUM; k++)
      if (h + k <= t) r = r | (TW'(v[h+k]) << (CW * k));
    return r;
  endfunction

  // chain structure now and after a pending mode write
  always_comb begin
    last_run = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      cas[i]  = (i != 0) && (mode_q[i][1:0] == CLK_CASC);
      nm[i]   = (mode_we && sel[i]) ? wbyte[i] : mode_q[i];
      ncas[i] = (i != 0) && (nm[i][1:0] == CLK_CASC);
      if (!cas[i]) last_run = run_q[i];
      chain_run[i] = last_run;
      view[i]      = chain_run[i] ? cnt_q[i] : base_q[i];
    end
  end

  // legality of a mode write
  always_comb begin
    mode_bad = 1'b0;
    go       = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (mode_we && sel[i]) begin
        if (wbyte[i][RSV_HI:RSV_LO] != '0) mode_bad = 1'b1;
        if (wbyte[i][BIT_RUN] && wbyte[i][BIT_LOAD]) mode_bad = 1'b1;
        if (wbyte[i][1:0] == 2'b01 || wbyte[i][1:0] == 2'b10) mode_bad = 1'b1;
        if (i == 0 && wbyte[i][1:0] == CLK_CASC) mode_bad = 1'b1;
        if (wbyte[i][BIT_RUN] && wbyte[i][1:0] == CLK_TICK) begin
          go = 1'b1;
          for (int j = 0; j < NUM; j++) begin
            if (j > i) begin
              if (go && ncas[j]) begin
                if (!nm[j][BIT_RUN]) mode_bad = 1'b1;
              end else begin
                go = 1'b0;
              end
            end
          end
        end
      end
    end
  end

  // counting, base writes, mode writes (later steps take precedence)
  always_comb begin
    mode_n = mode_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    run_n  = run_q;
    uf_n   = '0;
    top_c  = 0;
    top_s  = 0;
    cur    = '0;
    rl     = '0;
    for (int h = 0; h < NUM; h++) begin
      if (!cas[h] && run_q[h] && tick) begin
        top_c = chain_top(cas, h);
        cur   = pack_bytes(cnt_q, h, top_c);
        if (cur <= TW'(1)) begin
          cur         = pack_bytes(base_q, h, top_c);
          uf_n[top_c] = 1'b1;
        end else begin
          cur = cur - TW'(1);
        end
        for (int k = 0; k < NUM; k++)
          if (h + k <= top_c) cnt_n[h+k] = CW'(cur >> (CW * k));
      end
    end
    if (base_we) begin
      for (int i = 0; i < NUM; i++) begin
        if (sel[i]) begin
          base_n[i] = wbyte[i];
          if (!chain_run[i]) cnt_n[i] = wbyte[i];
        end
      end
    end
    if (mode_we && !mode_bad) begin
      for (int i = 0; i < NUM; i++) begin
        if (sel[i]) begin
          mode_n[i] = wbyte[i];
          run_n[i]  = 1'b0;
          if (wbyte[i][BIT_RUN] && wbyte[i][1:0] == CLK_TICK) begin
            top_s = chain_top(ncas, i);
            rl    = pack_bytes(base_q, i, top_s);
            if (rl != '0) begin
              run_n[i] = 1'b1;
              for (int k = 0; k < NUM; k++)
                if (i + k <= top_s) cnt_n[i+k] = CW'(rl >> (CW * k));
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      run_q   <= '0;
      uflow_q <= '0;
    end else begin
      mode_q  <= mode_n;
      base_q  <= base_n;
      cnt_q   <= cnt_n;
      run_q   <= run_n;
      uflow_q <= uf_n;
    end
  end

  AST_CTR0_NO_CASCADE: assert property (@(posedge clk) disable iff (!rst_n) mode_q[0][1:0] != CLK_CASC); // R3
  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n) (mode_we && mode_bad) |=> $stable(mode_q)); // R6

  for (genvar g = 0; g < NUM; g++) begin : g_chk
    AST_MODE_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) mode_q[g][RSV_HI:RSV_LO] == '0); // R4
    AST_RUN_HAS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) run_q[g] |-> mode_q[g][BIT_RUN]); // R9
    if (g < NUM - 1) begin : g_top
      AST_UFLOW_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n) uflow_q[g] |-> ($past(mode_q[g+1][1:0]) != CLK_CASC)); // R5
    end
  end
endmodule

// File: rtl/ctrbank_top.sv
module ctrbank_top
  import ctrbank_pkg::*;
#(
  parameter int NUM = 4,
  parameter int CW  = 8,
  parameter int DW  = 32,
  localparam int AW = $clog2(NUM) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [1:0]     req_size,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NUM-1:0] uflow,
  output logic           err
);
  grp_e                   grp;
  logic                   acc_ok, mode_we, base_we, mode_bad, bad;
  logic [NUM-1:0]         sel;
  logic [NUM-1:0][CW-1:0] wbyte, mode_q, base_q, view;
  logic [DW-1:0]          rdata;
  logic                   err_q, rsp_valid_q;
  logic [DW-1:0]          rsp_rdata_q;

  assign req_ready = 1'b1;

  ctrbank_access #(.NUM(NUM), .CW(CW), .DW(DW)) u_access (
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .mode_q    (mode_q),
    .base_q    (base_q),
    .view      (view),
    .grp       (grp),
    .acc_ok    (acc_ok),
    .sel       (sel),
    .wbyte     (wbyte),
    .rdata     (rdata)
  );

  assign mode_we = req_valid && req_write && acc_ok && (grp == GRP_MODE);
  assign base_we = req_valid && req_write && acc_ok && (grp == GRP_BASE);
  assign bad     = req_valid && (!acc_ok || (req_write && grp == GRP_COUNT)
                                || (mode_we && mode_bad));

  ctrbank_core #(.NUM(NUM), .CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode_we  (mode_we),
    .base_we  (base_we),
    .sel      (sel),
    .wbyte    (wbyte),
    .mode_q   (mode_q),
    .base_q   (base_q),
    .view     (view),
    .uflow_q  (uflow),
    .mode_bad (mode_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      err_q       <= bad;
      rsp_valid_q <= req_valid && !req_write;
      rsp_rdata_q <= (req_valid && !req_write && acc_ok) ? rdata : '0;
    end
  end

  assign err       = err_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_write) |=> rsp_valid); // R13
  AST_BAD_ACCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !acc_ok) |=> (err && rsp_rdata == '0)); // R11
  AST_COUNT_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_write && grp == GRP_COUNT) |=> err); // R10
endmodule

// File: tb/ctrbank_top_bench.sv
`timescale 1ns/1ps
module ctrbank_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  uflow;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ctrbank_top u_ctrbank_top (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .uflow(uflow), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request; returns data and error flag seen one cycle later
  task automatic access(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] d, output logic [31:0] rd, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata;
    e  = err;
    chk("R13 rsp_valid", {31'd0, rsp_valid}, {31'd0, ~wr});
  endtask

  task automatic wr_ok(input string tag, input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] rd; logic e;
    access(1'b1, a, sz, d, rd, e);
    chk(tag, {31'd0, e}, 32'd0);
  endtask

  task automatic wr_bad(input string tag, input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] rd; logic e;
    access(1'b1, a, sz, d, rd, e);
    chk(tag, {31'd0, e}, 32'd1);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp);
    logic [31:0] rd; logic e;
    access(1'b0, a, sz, 32'd0, rd, e);
    chk(tag, rd, exp);
  endtask

  task automatic tick_pulse(output logic [3:0] u);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    u = uflow;
  endtask

  task automatic test_reset;
    chk("R1 uflow idle", {28'd0, uflow}, 32'd0);
    chk("R1 err idle", {31'd0, err}, 32'd0);
    chk("R1 rsp idle", {31'd0, rsp_valid}, 32'd0);
    chk("R13 ready", {31'd0, req_ready}, 32'd1);
    rd_chk("R1 modes", 4'h0, 2'd2, 32'd0);
    rd_chk("R1 bases", 4'h4, 2'd2, 32'd0);
    rd_chk("R1 counters", 4'h8, 2'd2, 32'd0);
  endtask

  task automatic test_single;
    logic [3:0] u; int hits;
    wr_ok("R2 base1", 4'h5, 2'd0, 32'h03);
    wr_ok("R2 start1", 4'h1, 2'd0, 32'h80);
    rd_chk("R8 running full", 4'h9, 2'd0, 32'd3);
    tick_pulse(u); chk("R2 tick1", {28'd0, u}, 32'd0);
    rd_chk("R8 remaining", 4'h9, 2'd0, 32'd2);
    tick_pulse(u); chk("R2 tick2", {28'd0, u}, 32'd0);
    tick_pulse(u); chk("R2 underflow", {28'd0, u}, 32'h2);
    @(negedge clk); chk("R2 one-cycle pulse", {28'd0, uflow}, 32'd0);
    rd_chk("R2 reloaded", 4'h9, 2'd0, 32'd3);
    hits = 0;
    for (int n = 0; n < 6; n++) begin tick_pulse(u); if (u[1]) hits++; end
    chk("R2 periodic", hits, 32'd2);
    wr_ok("R9 stop1", 4'h1, 2'd0, 32'h00);
    hits = 0;
    for (int n = 0; n < 5; n++) begin tick_pulse(u); if (u != 0) hits++; end
    chk("R9 stopped silent", hits, 32'd0);
    rd_chk("R8 stopped reads base", 4'h9, 2'd0, 32'd3);
  endtask

  task automatic test_zero_reload;
    logic [3:0] u; int hits;
    wr_ok("R9 base2 zero", 4'h6, 2'd0, 32'h00);
    wr_ok("R9 start2", 4'h2, 2'd0, 32'h80);
    hits = 0;
    for (int n = 0; n < 3; n++) begin tick_pulse(u); if (u != 0) hits++; end
    chk("R9 zero reload idle", hits, 32'd0);
    wr_ok("R9 stop2", 4'h2, 2'd0, 32'h00);
  endtask

  task automatic test_cascade16;
    logic [3:0] u; int bad_seen;
    wr_ok("R5 base0", 4'h4, 2'd0, 32'h02);
    wr_ok("R5 base1", 4'h5, 2'd0, 32'h01);
    wr_ok("R5 casc1", 4'h1, 2'd0, 32'h83);
    wr_ok("R5 head0", 4'h0, 2'd0, 32'h80);
    rd_chk("R12 pair read", 4'h8, 2'd1, 32'h0201);
    bad_seen = 0;
    for (int n = 1; n <= 257; n++) begin
      tick_pulse(u);
      if (u != 0) bad_seen++;
      if (n == 1) rd_chk("R5 borrow", 4'h8, 2'd1, 32'h0101);
    end
    chk("R5 no early pulse", bad_seen, 32'd0);
    rd_chk("R5 last tick left", 4'h8, 2'd1, 32'h0100);
    tick_pulse(u); chk("R5 pulse on top only", {28'd0, u}, 32'h2);
    rd_chk("R5 wide reload", 4'h8, 2'd1, 32'h0201);
    wr_ok("R9 stop0", 4'h0, 2'd0, 32'h00);
    wr_ok("R9 clear1", 4'h1, 2'd0, 32'h00);
  endtask

  task automatic test_chain_check;
    logic [3:0] u;
    wr_ok("R6 casc2 idle", 4'h2, 2'd0, 32'h03);
    wr_bad("R6 member not enabled", 4'h1, 2'd0, 32'h80);
    rd_chk("R6 mode1 unchanged", 4'h1, 2'd0, 32'h00);
    wr_ok("R6 casc2 on", 4'h2, 2'd0, 32'h83);
    wr_ok("R6 casc3 on", 4'h3, 2'd0, 32'h83);
    wr_ok("R5 base1", 4'h5, 2'd0, 32'h01);
    wr_ok("R5 base2", 4'h6, 2'd0, 32'h00);
    wr_ok("R5 base3", 4'h7, 2'd0, 32'h00);
    wr_ok("R6 head1 start", 4'h1, 2'd0, 32'h80);
    rd_chk("R8 mixed view", 4'h8, 2'd2, 32'h02010000);
    tick_pulse(u); chk("R5 top is counter3", {28'd0, u}, 32'h8);
    tick_pulse(u); chk("R5 top repeats", {28'd0, u}, 32'h8);
    wr_ok("R9 stop1", 4'h1, 2'd0, 32'h00);
    wr_ok("R9 clear2", 4'h2, 2'd0, 32'h00);
    wr_ok("R9 clear3", 4'h3, 2'd0, 32'h00);
  endtask

  task automatic test_bad_modes;
    wr_bad("R3 cascade on counter0", 4'h0, 2'd0, 32'h83);
    wr_bad("R4 run plus load", 4'h0, 2'd0, 32'hC0);
    wr_bad("R4 reserved bit", 4'h0, 2'd0, 32'h84);
    wr_bad("R4 clock code 01", 4'h0, 2'd0, 32'h81);
    rd_chk("R3 mode0 unchanged", 4'h0, 2'd0, 32'h00);
    wr_ok("R4 load alone legal", 4'h0, 2'd0, 32'h40);
    rd_chk("R4 load stored", 4'h0, 2'd0, 32'h40);
    wr_ok("R4 restore", 4'h0, 2'd0, 32'h00);
  endtask

  task automatic test_access;
    logic [31:0] rd; logic e;
    wr_bad("R10 counter write", 4'h8, 2'd0, 32'h77);
    rd_chk("R10 counter unchanged", 4'h8, 2'd0, 32'h02);
    access(1'b0, 4'h1, 2'd1, 32'd0, rd, e);
    chk("R11 pair at 1 err", {31'd0, e}, 32'd1);
    chk("R11 pair at 1 data", rd, 32'd0);
    wr_bad("R11 word at 2", 4'h6, 2'd2, 32'hFFFF_FFFF);
    wr_bad("R11 size 3", 4'h4, 2'd3, 32'h0);
    access(1'b0, 4'hC, 2'd0, 32'd0, rd, e);
    chk("R11 group 3", {31'd0, e}, 32'd1);
    wr_ok("R12 pair write", 4'h6, 2'd1, 32'h0000ABCD);
    rd_chk("R12 pair hi byte", 4'h6, 2'd0, 32'hAB);
    rd_chk("R12 pair lo byte", 4'h7, 2'd0, 32'hCD);
    wr_ok("R12 word write", 4'h4, 2'd2, 32'h11223344);
    rd_chk("R12 word byte0", 4'h4, 2'd0, 32'h11);
    rd_chk("R12 word byte3", 4'h7, 2'd0, 32'h44);
    rd_chk("R12 word read", 4'h4, 2'd2, 32'h11223344);
  endtask

  task automatic test_deferred_base;
    logic [3:0] u;
    wr_ok("R7 base0", 4'h4, 2'd0, 32'h04);
    wr_ok("R7 start0", 4'h0, 2'd0, 32'h80);
    tick_pulse(u);
    rd_chk("R7 count 3", 4'h8, 2'd0, 32'd3);
    wr_ok("R7 base write running", 4'h4, 2'd0, 32'h02);
    rd_chk("R7 count kept", 4'h8, 2'd0, 32'd3);
    tick_pulse(u); tick_pulse(u);
    rd_chk("R7 count 1", 4'h8, 2'd0, 32'd1);
    // base write and reloading tick on the same edge
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h4; req_size = 2'd0;
    req_wdata = 32'h05; tick = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
    chk("R7 same-cycle pulse", {28'd0, uflow}, 32'h1);
    chk("R7 same-cycle no err", {31'd0, err}, 32'd0);
    rd_chk("R7 reload used old base", 4'h8, 2'd0, 32'd2);
    rd_chk("R7 new base stored", 4'h4, 2'd0, 32'd5);
    tick_pulse(u); chk("R7 no pulse yet", {28'd0, u}, 32'd0);
    tick_pulse(u); chk("R7 pulse after old period", {28'd0, u}, 32'h1);
    rd_chk("R7 new base in effect", 4'h8, 2'd0, 32'd5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_single();
    test_zero_reload();
    test_cascade16();
    test_chain_check();
    test_bad_modes();
    test_access();
    test_deferred_base();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule